// File: doc/BRIEF.md
# Stable Matching Crossbar Scheduler

This block pairs the N outputs of a crossbar with its N inputs one to one, so that no output and input would both rather be paired with each other than with the partners they were given. Outputs make the offers. Each output holds an ordered list of inputs, from most wanted to least wanted. Each input holds a rank for every output. Both sides are written through a small configuration port while the block is idle.

A start pulse clears all pairings and begins a loop that handles one offer per clock. On each cycle the lowest-numbered output that is still unpaired offers itself to the next input on its list. A free input accepts. An input that is already paired accepts only if it ranks the new output better than its current partner, and that partner becomes unpaired. When no output is left unpaired, the block registers the result vector and raises a done flag. Both stay unchanged until the next start.

Top module: `stable_match_sched`

## Requirements
- R1: After reset, `busy` and `done` are 0 and `match` is all zeros.
- R2: A write with `cfg_side`=0 stores input `cfg_val` as choice number `cfg_pos` (0 = most wanted) in the list of output `cfg_port`. Each list is a permutation of the inputs.
- R3: A write with `cfg_side`=1 stores rank `cfg_val` (0 = best) that input `cfg_port` gives output `cfg_pos`. An input accepts an offer from a paired state only on a strictly smaller rank.
- R4: The result equals the outcome of the offer loop described above, with the lowest-numbered unpaired output offering first. Field `match[p*W +: W]` holds the input paired with output p, where W = clog2(N).
- R5: The result is one to one and has no blocking pair. A blocking pair is an output and an input that each prefer the other over their own partner.
- R6: `done` rises no more than N*N+1 clock edges after the edge that samples `start`. `busy` is high from that edge until `done` rises.
- R7: While `done` is high and `start` is low, `done` and `match` stay unchanged.
- R8: Configuration writes made while `busy` is high are discarded.
- R9: On the edge after `start` is sampled, `done` is 0 and `busy` is 1, whatever the previous state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_side | input | 1 | 0: output choice list, 1: input rank table |
| cfg_port | input | clog2(N) | Owner of the entry being written |
| cfg_pos | input | clog2(N) | Choice position (side 0) or ranked output (side 1) |
| cfg_val | input | clog2(N) | Input index (side 0) or rank (side 1) |
| start | input | 1 | Begin a new matching run |
| busy | output | 1 | Run in progress |
| done | output | 1 | Result valid and held |
| match | output | N*clog2(N) | Input paired with each output |

## Verification
A corrupted pointer or partner register does not stay hidden. It shows up on the `match` port as soon as `done` rises: either two outputs name the same input, or the bench finds an output and an input that both prefer each other. Both are checked on every run. A lost "free" flag would keep the loop going or end it too early, which shows as `done` missing its N*N+1 edge deadline or as a result that differs from the bench's own offer-loop model. A write that slips through during a run shows up on a repeat run, when the stored lists no longer give the expected result.

// File: rtl/sms_pkg.sv
package sms_pkg;
  localparam int unsigned SMS_DEF_PORTS = 4;
  localparam int unsigned SMS_PROP_RD   = 1;
  localparam int unsigned SMS_ACC_RD    = 2;
endpackage

// File: rtl/sms_pref_table.sv
module sms_pref_table #(
  parameter int unsigned N   = 4,
  parameter int unsigned NRD = 1
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [2*$clog2(N)-1:0]   waddr,
  input  logic [$clog2(N)-1:0]     wdata,
  input  logic [NRD*2*$clog2(N)-1:0] raddr,
  output logic [NRD*$clog2(N)-1:0] rdata
);
  localparam int unsigned IW    = $clog2(N);
  localparam int unsigned AW    = 2 * IW;
  localparam int unsigned DEPTH = 1 << AW;

  logic [IW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rdata[g*IW +: IW] = mem[raddr[g*AW +: AW]];
  end
endmodule

// File: rtl/sms_free_pick.sv
module sms_free_pick #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0]         req,
  output logic                 any,
  output logic [$clog2(N)-1:0] idx
);
  localparam int unsigned IW = $clog2(N);

  always_comb begin
    any = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end

  always_comb begin
    if (any) assert_pick_valid_R4: assert (req[idx]);
  end
endmodule

// File: rtl/sms_engine.sv
module sms_engine #(
  parameter int unsigned N = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  input  logic [$clog2(N)-1:0]   choice,
  input  logic [2*$clog2(N)-1:0] ranks,
  output logic [2*$clog2(N)-1:0] prop_raddr,
  output logic [4*$clog2(N)-1:0] acc_raddr,
  output logic                   busy,
  output logic                   done,
  output logic [N*$clog2(N)-1:0] match
);
  localparam int unsigned IW = $clog2(N);
  localparam int unsigned CW = $clog2(N*N + 1);

  logic          run_q, done_q;
  logic [N-1:0]  p_free, a_free;
  logic [IW-1:0] p_ptr  [N];
  logic [IW-1:0] p_mate [N];
  logic [IW-1:0] a_mate [N];
  logic [N*IW-1:0] match_q;
  logic [CW-1:0] cnt;

  logic          any_free;
  logic [IW-1:0] sel, tgt, rank_new, rank_cur;
  logic          accept;

  sms_free_pick #(.N(N)) u_pick (.req(p_free), .any(any_free), .idx(sel));

  assign tgt        = choice;
  assign rank_new   = ranks[0 +: IW];
  assign rank_cur   = ranks[IW +: IW];
  assign prop_raddr = {sel, p_ptr[sel]};
  assign acc_raddr  = {tgt, a_mate[tgt], tgt, sel};
  assign accept     = a_free[tgt] || (rank_new < rank_cur);

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q   <= 1'b0;
      done_q  <= 1'b0;
      match_q <= '0;
      p_free  <= '0;
      a_free  <= '0;
      cnt     <= '0;
      for (int i = 0; i < N; i++) begin
        p_ptr[i]  <= '0;
        p_mate[i] <= '0;
        a_mate[i] <= '0;
      end
    end else if (start) begin
      run_q  <= 1'b1;
      done_q <= 1'b0;
      p_free <= '1;
      a_free <= '1;
      cnt    <= '0;
      for (int i = 0; i < N; i++) p_ptr[i] <= '0;
    end else if (run_q) begin
      if (any_free) begin
        p_ptr[sel] <= p_ptr[sel] + 1'b1;
        cnt        <= cnt + 1'b1;
        if (accept) begin
          p_free[sel] <= 1'b0;
          p_mate[sel] <= tgt;
          a_free[tgt] <= 1'b0;
          a_mate[tgt] <= sel;
          if (!a_free[tgt]) p_free[a_mate[tgt]] <= 1'b1;
        end
      end else begin
        run_q  <= 1'b0;
        done_q <= 1'b1;
        for (int i = 0; i < N; i++) match_q[i*IW +: IW] <= p_mate[i];
      end
    end
  end

  assign busy  = run_q;
  assign done  = done_q;
  assign match = match_q;

  logic [N-1:0] acc_hit;
  always_comb begin
    acc_hit = '0;
    for (int i = 0; i < N; i++) acc_hit[match_q[i*IW +: IW]] = 1'b1;
  end

  assert_done_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (done_q && !start) |=> (done_q && $stable(match_q)));
  assert_start_clears_R9: assert property (@(posedge clk) disable iff (rst)
    start |=> (run_q && !done_q));
  assert_offer_bound_R6: assert property (@(posedge clk) disable iff (rst)
    run_q |-> (cnt <= CW'(N*N)));
  assert_finish_R6: assert property (@(posedge clk) disable iff (rst)
    (run_q && !any_free && !start) |=> done_q);
  assert_one_to_one_R5: assert property (@(posedge clk) disable iff (rst)
    done_q |-> ($countones(acc_hit) == N));
  assert_free_balance_R4: assert property (@(posedge clk) disable iff (rst)
    run_q |-> ($countones(p_free) == $countones(a_free)));
endmodule

// File: rtl/stable_match_sched.sv
module stable_match_sched #(
  parameter int unsigned N = sms_pkg::SMS_DEF_PORTS
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cfg_we,
  input  logic                   cfg_side,
  input  logic [$clog2(N)-1:0]   cfg_port,
  input  logic [$clog2(N)-1:0]   cfg_pos,
  input  logic [$clog2(N)-1:0]   cfg_val,
  input  logic                   start,
  output logic                   busy,
  output logic                   done,
  output logic [N*$clog2(N)-1:0] match
);
  localparam int unsigned IW = $clog2(N);
  localparam int unsigned AW = 2 * IW;

  logic          we_prop, we_acc;
  logic [AW-1:0] waddr;
  logic [AW-1:0] prop_raddr;
  logic [2*AW-1:0] acc_raddr;
  logic [IW-1:0] choice;
  logic [2*IW-1:0] ranks;

  assign we_prop = cfg_we && !busy && !cfg_side;
  assign we_acc  = cfg_we && !busy &&  cfg_side;
  assign waddr   = {cfg_port, cfg_pos};

  sms_pref_table #(.N(N), .NRD(sms_pkg::SMS_PROP_RD)) u_prop_tab (
    .clk(clk), .we(we_prop), .waddr(waddr), .wdata(cfg_val),
    .raddr(prop_raddr), .rdata(choice));

  sms_pref_table #(.N(N), .NRD(sms_pkg::SMS_ACC_RD)) u_acc_tab (
    .clk(clk), .we(we_acc), .waddr(waddr), .wdata(cfg_val),
    .raddr(acc_raddr), .rdata(ranks));

  sms_engine #(.N(N)) u_engine (
    .clk(clk), .rst(rst), .start(start),
    .choice(choice), .ranks(ranks),
    .prop_raddr(prop_raddr), .acc_raddr(acc_raddr),
    .busy(busy), .done(done), .match(match));

  assert_write_blocked_R8: assert property (@(posedge clk) disable iff (rst)
    busy |-> !(we_prop || we_acc));
endmodule

// File: tb/stable_match_sched_tb.sv
module stable_match_sched_tb;
  localparam int N  = 4;
  localparam int IW = 2;
  localparam int CLK_PERIOD = 10;
  localparam int VW = N*N*IW;

  logic clk = 1'b0, rst = 1'b1;
  logic cfg_we = 1'b0, cfg_side = 1'b0, start = 1'b0;
  logic [IW-1:0] cfg_port = '0, cfg_pos = '0, cfg_val = '0;
  logic busy, done;
  logic [N*IW-1:0] match;

  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stable_match_sched #(.N(N)) u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_side(cfg_side),
    .cfg_port(cfg_port), .cfg_pos(cfg_pos), .cfg_val(cfg_val),
    .start(start), .busy(busy), .done(done), .match(match));

  // {choice lists, acceptor ranks, expected match}
  localparam logic [2*VW+N*IW-1:0] VEC [3] = '{
    {32'h934E39E4, 32'h934E39E4, 8'hE4},
    {32'hE4E4E4E4, 32'h1B1B1B1B, 8'h1B},
    {32'h1B1B1B1B, 32'hE4E4E4E4, 8'h1B}
  };
  localparam string VTAG [3] = '{"R2", "R3", "R3"};

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic side, input int port, input int pos, input int val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_side = side;
    cfg_port = IW'(port); cfg_pos = IW'(pos); cfg_val = IW'(val);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic load(input logic [VW-1:0] pl, input logic [VW-1:0] ar);
    for (int p = 0; p < N; p++)
      for (int k = 0; k < N; k++) begin
        wr(1'b0, p, k, int'(pl[(p*N+k)*IW +: IW]));
        wr(1'b1, p, k, int'(ar[(p*N+k)*IW +: IW]));
      end
  endtask

  // pulse start; returns edges until done
  task automatic run(output int cyc);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(busy === 1'b1 && done === 1'b0, "R9", {busy, done}, 2'b10);
    cyc = 1;
    while (!done && cyc <= N*N + 2) begin
      @(negedge clk); cyc++;
    end
    check(cyc <= N*N + 1 && busy === 1'b0, "R6", cyc, N*N + 1);
  endtask

  function automatic logic [N*IW-1:0] model(input logic [VW-1:0] pl, input logic [VW-1:0] ar);
    int ptr[N], pm[N], am[N];
    bit pf[N], af[N];
    logic [N*IW-1:0] r;
    for (int i = 0; i < N; i++) begin ptr[i] = 0; pf[i] = 1; af[i] = 1; pm[i] = 0; am[i] = 0; end
    for (int step = 0; step < 2*N*N; step++) begin
      int p; int a;
      p = -1;
      for (int i = N-1; i >= 0; i--) if (pf[i]) p = i;
      if (p < 0) break;
      a = int'(pl[(p*N+ptr[p])*IW +: IW]);
      ptr[p] = (ptr[p] + 1) % N;
      if (af[a]) begin
        af[a] = 0; pf[p] = 0; pm[p] = a; am[a] = p;
      end else if (ar[(a*N+p)*IW +: IW] < ar[(a*N+am[a])*IW +: IW]) begin
        pf[am[a]] = 1; pf[p] = 0; pm[p] = a; am[a] = p;
      end
    end
    for (int i = 0; i < N; i++) r[i*IW +: IW] = IW'(pm[i]);
    return r;
  endfunction

  // 1 when the result is one to one and has no blocking pair
  function automatic bit stable_ok(input logic [VW-1:0] pl, input logic [VW-1:0] ar, input logic [N*IW-1:0] m);
    int owner[N], posof[N][N];
    for (int a = 0; a < N; a++) owner[a] = -1;
    for (int p = 0; p < N; p++) begin
      int a; a = int'(m[p*IW +: IW]);
      if (owner[a] >= 0) return 0;
      owner[a] = p;
      for (int k = 0; k < N; k++) posof[p][int'(pl[(p*N+k)*IW +: IW])] = k;
    end
    for (int p = 0; p < N; p++)
      for (int a = 0; a < N; a++) begin
        int mine; int q;
        mine = int'(m[p*IW +: IW]);
        q = owner[a];
        if (a != mine && posof[p][a] < posof[p][mine] &&
            ar[(a*N+p)*IW +: IW] < ar[(a*N+q)*IW +: IW]) return 0;
      end
    return 1;
  endfunction

  function automatic logic [N*IW-1:0] perm(input logic [31:0] s);
    int arr[N]; int t; logic [N*IW-1:0] r;
    for (int i = 0; i < N; i++) arr[i] = i;
    for (int i = N-1; i > 0; i--) begin
      int j; j = int'(s % (i+1)); s = s / (i+1);
      t = arr[i]; arr[i] = arr[j]; arr[j] = t;
    end
    for (int i = 0; i < N; i++) r[i*IW +: IW] = IW'(arr[i]);
    return r;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] lfsr;
    logic [VW-1:0] pl, ar;
    logic [N*IW-1:0] held;
    int cyc;
    lfsr = 32'hACE1_1234;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(busy === 1'b0 && done === 1'b0 && match === '0, "R1", {busy, done, match}, 0);

    foreach (VEC[v]) begin
      pl = VEC[v][2*VW+N*IW-1 -: VW];
      ar = VEC[v][VW+N*IW-1 -: VW];
      load(pl, ar);
      run(cyc);
      check(match === VEC[v][N*IW-1:0], VTAG[v], match, VEC[v][N*IW-1:0]);
      check(match === model(pl, ar), "R4", match, model(pl, ar));
      check(stable_ok(pl, ar, match), "R5", match, 0);
    end

    // R7: result held across idle cycles and idle configuration writes
    held = match;
    repeat (5) @(negedge clk);
    check(done === 1'b1 && match === held, "R7", match, held);
    wr(1'b0, 0, 0, 3);
    wr(1'b1, 2, 1, 0);
    check(done === 1'b1 && match === held, "R7", match, held);

    // R8: write during a run must not reach the tables
    pl = 32'hE4E4E4E4; ar = 32'h1B1B1B1B;
    load(pl, ar);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    cfg_we = 1'b1; cfg_side = 1'b0; cfg_port = 2'd3; cfg_pos = 2'd0; cfg_val = 2'd3;
    @(negedge clk); cfg_we = 1'b0;
    cyc = 0;
    while (!done && cyc < N*N + 2) begin @(negedge clk); cyc++; end
    check(match === 8'h1B, "R8", match, 8'h1B);
    run(cyc);
    check(match === 8'h1B, "R8", match, 8'h1B);

    // R9: start issued while a result is held restarts cleanly (checked in run)
    for (int t = 0; t < 24; t++) begin
      for (int p = 0; p < N; p++) begin
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        pl[p*N*IW +: N*IW] = perm(lfsr);
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        ar[p*N*IW +: N*IW] = perm(lfsr);
      end
      load(pl, ar);
      run(cyc);
      check(match === model(pl, ar), "R4", match, model(pl, ar));
      check(stable_ok(pl, ar, match), "R5", match, 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule